// File: doc/BRIEF.md
# Programmable Row Delay with Difference Output

This block is a video line buffer built around a single-port word memory, by default 1024 words of 24 bits. A free-running write address counter walks the memory one word per clock. Pulsing the active-low restart input sends the counter back to word zero, so the interval between restart pulses sets how far back in time the stored samples lie. Each clock, the memory word under the counter is read out, then overwritten with a newer input sample.

Two function codes select what reaches the registered output. In plain delay mode the output is the input sample from N-1 clock edges earlier. In difference mode the output is that delayed sample minus the sample captured three edges earlier. The subtraction wraps in two's complement. Any other function code forces the output to zero. The delay length N equals the restart period plus four.

Top module: `row_delay_sub`

## Requirements
- R1: A clock edge with `restart_n` low loads write address 0. Any other edge advances the address by one, until the address reaches DEPTH-1.
- R2: The block samples `din` at every edge. The sample taken at edge k, written D(k), is stored at the write address two edges later. The old word at that address is read before the new word overwrites it.
- R3: With `func_code` = 3'b101 and restart pulses every P edges (2 <= P <= DEPTH), `dout` after edge c equals D(c-N+1), where N = P+4. This gives delay lengths from 6 to DEPTH+4.
- R4: When no restart occurs, the address holds at DEPTH-1 and memory writes stop from the next edge. After a restart at edge r, `dout` in mode 3'b101 settles to the constant D(r+DEPTH-2) from edge r+DEPTH+2 onward.
- R5: With `func_code` = 3'b010, `dout` after edge c equals D(c-N+1) minus D(c-3), modulo 2^W.
- R6: Any `func_code` other than 3'b101 or 3'b010 sampled at an edge sets `dout` to zero at that edge.
- R7: While `rst_n` is low, `dout` is zero. The address is parked at DEPTH-1 with writes off until the first restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_n | input | 1 | Active-low restart of the write address counter |
| func_code | input | 3 | 3'b101 plain delay, 3'b010 difference, any other value gives a zero output |
| din | input | W (24) | Input sample stream |
| dout | output | W (24) | Registered output |

## Verification
The bench builds the block with DEPTH = 32 and W = 24. The longest restart period, 32 cycles, then covers every memory word within a few dozen cycles. The parked-counter behaviour at the top word is reached quickly, and so is the delay range limit of 36. Restart periods of 2, 6, 11 and 32 run in both modes against a history of inputs kept in the bench. The subtracted values are scrambled enough to wrap past zero.

// File: rtl/row_delay_pkg.sv
// Shared definitions for the row delay block.
// Assumes: function codes are compared as raw 3-bit values.
package row_delay_pkg;
    localparam logic [2:0] FN_DELAY = 3'b101;  // plain delayed output
    localparam logic [2:0] FN_DIFF  = 3'b010;  // delayed minus recent sample
    localparam int unsigned IN_STAGES = 3;     // input registers ahead of the subtractor
endpackage

// File: rtl/rd_addr_ctr.sv
// Write address counter for the row delay memory.
// Restart (active low) loads zero. Otherwise the counter counts up and
// parks at DEPTH-1. While parked, the write enable is withdrawn.
// Assumes: DEPTH is a power of two, at least 4.
module rd_addr_ctr #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_n,
    output logic [AW-1:0] addr,
    output logic          wr_ok
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic parked;

    // Address sequencing: restart, advance, or park at the top word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= TOP;
            parked <= 1'b1;
        end else if (!restart_n) begin
            addr   <= '0;
            parked <= 1'b0;
        end else if (addr == TOP) begin
            parked <= 1'b1;
        end else begin
            addr <= addr + AW'(1);
        end
    end

    assign wr_ok = !parked;
endmodule

// File: rtl/rd_line_mem.sv
// Single-port line memory. The registered read returns the old word,
// and the same edge writes the new one (read before write).
// Assumes: the storage itself is not reset; only the read register is.
module rd_line_mem #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 24,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    // Storage write, gated by the counter's enable.
    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    // Registered read of the word about to be replaced.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= store[addr];
    end
endmodule

// File: rtl/rd_datapath.sv
// Input alignment pipeline and output stage with the optional subtractor.
// tap_wr feeds the memory, two edges after sampling. tap_sub is the sample
// from three edges back, used by the difference mode.
// Assumes: func_code is sampled on the same edge that loads dout.
module rd_datapath
    import row_delay_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   func_code,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mem_rd,
    output logic [W-1:0] tap_wr,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [IN_STAGES];

    // Input shift chain aligning samples with the address pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IN_STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < IN_STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign tap_wr = pipe[1];

    // Output register: delayed word, difference, or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else begin
            case (func_code)
                FN_DELAY: dout <= mem_rd;
                FN_DIFF:  dout <= mem_rd - pipe[IN_STAGES-1];
                default:  dout <= '0;
            endcase
        end
    end
endmodule

// File: rtl/row_delay_sub.sv
// Programmable row delay with difference output.
// The delay length is the restart period plus four.
// Assumes: the restart period lies between 2 and DEPTH.
module row_delay_sub #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_n,
    input  logic [2:0]   func_code,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [AW-1:0] wr_addr;
    logic          wr_en;
    logic [W-1:0]  wr_data;
    logic [W-1:0]  rd_data;

    rd_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk(clk), .rst_n(rst_n), .restart_n(restart_n),
        .addr(wr_addr), .wr_ok(wr_en)
    );

    rd_line_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(wr_addr), .we(wr_en),
        .wdata(wr_data), .rdata(rd_data)
    );

    rd_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .func_code(func_code), .din(din),
        .mem_rd(rd_data), .tap_wr(wr_data), .dout(dout)
    );
endmodule

// File: rtl/row_delay_sub_chk.sv
// Checker for row_delay_sub: counter sequencing, parking and output gating.
module row_delay_sub_chk #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 24,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart_n,
    input logic [2:0]    func_code,
    input logic [AW-1:0] addr,
    input logic          wr_ok,
    input logic [W-1:0]  dout
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    // R1
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_n |=> addr == '0);

    // R1
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_n && addr != TOP) |=> addr == $past(addr) + AW'(1));

    // R4
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_n && addr == TOP) |=> addr == TOP);

    // R4
    top_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_n && addr == TOP) |=> !wr_ok);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_code != 3'b101 && func_code != 3'b010) |=> dout == '0);
endmodule

bind row_delay_sub row_delay_sub_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart_n(restart_n), .func_code(func_code),
    .addr(wr_addr), .wr_ok(wr_en), .dout(dout)
);

// File: tb/row_delay_sub_tb.sv
`timescale 1ns/1ps
module row_delay_sub_tb;
    localparam int DEPTH = 32;
    localparam int W     = 24;
    localparam int HN    = 4096;
    // vectors: function code, restart period, steps
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{5, 2, 40}, '{5, 6, 60}, '{2, 6, 60}, '{2, 2, 40},
        '{5, 11, 70}, '{5, DEPTH, 3*DEPTH}, '{2, DEPTH, 3*DEPTH}, '{2, 11, 70}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart_n = 1'b1;
    logic [2:0]   func_code = 3'b101;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [W-1:0] hist [HN];
    bit chk_en = 0;
    int chk_from = 0;
    int n_exp = 0;
    bit diff_mode = 0;
    bit done = 0;

    row_delay_sub #(.DEPTH(DEPTH), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart_n(restart_n),
        .func_code(func_code), .din(din), .dout(dout)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] pat(input int k);
        return W'((k + 7) * 40503) ^ W'(k << 11);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d got=%h exp=%h", tag, cyc, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, record at the rising edge, check at the next falling edge.
    task automatic step(input logic [W-1:0] d, input logic rs);
        din = d;
        restart_n = rs;
        @(posedge clk);
        cyc++;
        hist[cyc % HN] = d;
        @(negedge clk);
        if (chk_en && cyc >= chk_from) begin
            logic [W-1:0] e;
            e = hist[(cyc - n_exp + 1) % HN];
            if (diff_mode) begin
                e = e - hist[(cyc - 3) % HN];
                check("R5", dout, e);          // also exercises R1 R2
            end else begin
                check("R3", dout, e);          // also exercises R1 R2
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        @(negedge clk);
        // R7: output zero during reset
        repeat (3) @(negedge clk);
        check("R7", dout, '0);
        rst_n = 1'b1;

        // table walk: both modes, several restart periods
        for (int v = 0; v < NV; v++) begin
            func_code = 3'(VEC[v][0]);
            diff_mode = (VEC[v][0] == 2);
            n_exp     = VEC[v][1] + 4;
            chk_from  = cyc + 1 + VEC[v][1] + 2;
            chk_en    = 1;
            for (int k = 0; k < VEC[v][2]; k++)
                step(pat(cyc), (k % VEC[v][1]) == 0 ? 1'b0 : 1'b1);
            chk_en = 0;
        end

        // R4: one restart, then no more; the output settles on the top word
        func_code = 3'b101;
        step(pat(cyc), 1'b0);
        r = cyc;
        for (int k = 0; k < 3*DEPTH; k++) begin
            step(pat(cyc), 1'b1);
            if (cyc >= r + DEPTH + 2)
                check("R4", dout, hist[(r + DEPTH - 2) % HN]);
        end

        // R6: unused codes give zero on the next edge
        func_code = 3'b000;
        step(pat(cyc), 1'b1);
        check("R6", dout, '0);
        func_code = 3'b111;
        step(pat(cyc), 1'b1);
        check("R6", dout, '0);
        func_code = 3'b101;
        step(pat(cyc), 1'b1);
        check("R6", dout, hist[(r + DEPTH - 2) % HN]);

        // R7: reset in mid-run clears the output
        rst_n = 1'b0;
        step(pat(cyc), 1'b1);
        check("R7", dout, '0);
        rst_n = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule